// File: doc/BRIEF.md
# Prioritized Interrupt Arbiter with Acknowledge

This block collects 64 level-driven interrupt sources and drives two request lines toward a processor: a normal request and a fast request. Each source carries an enable bit, a fast-class bit and a 4-bit priority. These settings live in registers inside the block and are loaded through whole-vector write strobes. A source whose level rises becomes pending. A source whose level falls stops being pending. Only pending sources that are enabled take part in arbitration.

The fast class has no priority. Its request rises whenever any enabled fast source is pending. An acknowledge on that class yields the lowest-numbered such source. The normal class is arbitrated by priority, and a 5-bit threshold gates it. The all-ones threshold passes every candidate. Any other threshold passes only candidates whose priority is strictly above it. Each class presents its vector word combinationally at all times. An acknowledge strobe takes the word shown in that cycle and retires the winning source's pending bit at the next clock edge. The source then stays retired until its level goes low and high again.

The state is: the pending vector, the registered previous levels, the configuration registers and the two registered request flags. The block has no sequencer. Both request lines follow the state with one cycle of delay.

Top module: `irq_prio_arbiter`

## Requirements
- R1: After reset, nothing is pending and no source is enabled or fast. Every priority is zero and the threshold is 5'h1F. Both request lines are low, and both vector words read 32'hFFFF_FFFF.
- R2: A rising edge on a source level sets that source's pending bit at the clock edge that samples the rise. A falling edge clears it at the edge that samples the fall.
- R3: The fast request is a register. It goes high one cycle after the state holds a pending, enabled, fast source, and low one cycle after no such source remains. Priorities and the threshold play no part in it.
- R4: With the threshold at 5'h1F, the normal request goes high one cycle after any pending, enabled, non-fast source exists, whatever its priority.
- R5: With any other threshold, the normal request goes high one cycle later only if some candidate has a priority strictly greater than the threshold. A threshold of 16 or more therefore blocks it.
- R6: The normal vector word selects the candidate with the highest priority. Among equal priorities, the higher source index wins. The word carries the index in bits 31:16 and the zero-extended priority in bits 15:0. With no candidate, the word is 32'hFFFF_FFFF.
- R7: A normal acknowledge clears the pending bit of the source its word names at that edge. With no candidate, the acknowledge changes nothing.
- R8: The fast vector word is the lowest-indexed pending, enabled, fast source, zero-extended, or 32'hFFFF_FFFF when there is none. A fast acknowledge clears that source's pending bit.
- R9: An acknowledge clear wins over a set on the same bit. A cleared source stays clear while its level stays high, and it becomes pending again only on a new rising edge.
- R10: Each write strobe loads its whole vector at the next edge. The priority of source i is bits 4i+3:4i of the priority vector.
- R11: A disabled source never appears in either class. A fast source never appears in the normal word or the normal request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_lvl | input | 64 | Source levels, bit i is source i |
| en_wr | input | 1 | Load strobe for the enable vector |
| en_val | input | 64 | New enable vector |
| fast_wr | input | 1 | Load strobe for the fast-class vector |
| fast_val | input | 64 | New fast-class vector, 1 = fast |
| prio_wr | input | 1 | Load strobe for the priority vector |
| prio_val | input | 256 | New priorities, source i at bits 4i+3:4i |
| mask_wr | input | 1 | Load strobe for the threshold |
| mask_val | input | 5 | New threshold |
| nack | input | 1 | Normal-class acknowledge strobe |
| fack | input | 1 | Fast-class acknowledge strobe |
| nreq | output | 1 | Registered normal request |
| freq | output | 1 | Registered fast request |
| nvec | output | 32 | Normal vector word |
| fvec | output | 32 | Fast vector word |

## Verification
Directed sequences cover several cases:
- equal priorities at two indices, which separates the tie-break toward the higher index from a lowest-first search;
- thresholds just below, at and above the only priority present, plus a threshold in the 16..30 range, which expose an off-by-one in the strict comparison;
- repeated acknowledges while the source levels stay high, which separate edge-based setting from level following;
- fast sources carrying a high priority, which show that the fast class ignores priority.

Random traffic then mixes level toggles, rewrites of every configuration register with priorities biased toward ties, and acknowledges on both classes. A bench model checks all four outputs every cycle.

// File: rtl/irqa_pkg.sv
package irqa_pkg;
    localparam int SRC_N  = 64;
    localparam int PRIO_W = 4;
    localparam int MASK_W = 5;
    localparam int IDX_W  = $clog2(SRC_N);
    localparam int VEC_W  = 32;

    typedef struct packed {
        logic              vld;
        logic [PRIO_W-1:0] prio;
        logic [IDX_W-1:0]  idx;
    } cand_t;
endpackage

// File: rtl/irqa_cfg_regs.sv
module irqa_cfg_regs
    import irqa_pkg::*;
#(
    parameter int N  = SRC_N,
    parameter int PW = PRIO_W,
    parameter int MW = MASK_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_wr,
    input  logic [N-1:0]  en_val,
    input  logic          fast_wr,
    input  logic [N-1:0]  fast_val,
    input  logic          prio_wr,
    input  logic [N*PW-1:0] prio_val,
    input  logic          mask_wr,
    input  logic [MW-1:0] mask_val,
    output logic [N-1:0]  en_q,
    output logic [N-1:0]  fast_q,
    output logic [N*PW-1:0] prio_q,
    output logic [MW-1:0] mask_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= '0;
            fast_q <= '0;
            prio_q <= '0;
            mask_q <= '1;
        end else begin
            if (en_wr)   en_q   <= en_val;
            if (fast_wr) fast_q <= fast_val;
            if (prio_wr) prio_q <= prio_val;
            if (mask_wr) mask_q <= mask_val;
        end
    end

    p_mask_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (mask_q == '1 && en_q == '0 && fast_q == '0 && prio_q == '0));
endmodule

// File: rtl/irqa_pend_bank.sv
module irqa_pend_bank
    import irqa_pkg::*;
#(
    parameter int N = SRC_N
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl,
    input  logic [N-1:0] clr,
    output logic [N-1:0] pend_q
);
    logic [N-1:0] lvl_q;
    logic [N-1:0] rise;
    logic [N-1:0] fall;

    assign rise = lvl & ~lvl_q;
    assign fall = ~lvl & lvl_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_q  <= '0;
            pend_q <= '0;
        end else begin
            lvl_q  <= lvl;
            pend_q <= (pend_q | rise) & ~fall & ~clr;
        end
    end

    p_rise_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((rise & ~clr) != '0) |=>
        ((pend_q & $past(rise & ~clr)) == $past(rise & ~clr)));

    p_fall_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (fall != '0) |=> ((pend_q & $past(fall)) == '0));

    p_clr_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr != '0) |=> ((pend_q & $past(clr)) == '0));

    p_set_needs_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend_q & ~$past(pend_q) & ~$past(rise)) == '0));
endmodule

// File: rtl/irqa_pick_tree.sv
module irqa_pick_tree
    import irqa_pkg::*;
#(
    parameter int N       = SRC_N,
    parameter int PW      = PRIO_W,
    parameter bit BY_PRIO = 1'b1
) (
    input  logic [N-1:0]    req,
    input  logic [N*PW-1:0] prio,
    output cand_t           win
);
    localparam int NODES = 2 * N - 1;
    localparam int LEAF0 = N - 1;

    cand_t node [NODES];

    for (genvar i = 0; i < N; i++) begin : g_leaf
        logic [PW-1:0] pr;
        assign pr = BY_PRIO ? prio[i*PW +: PW] : '0;
        assign node[LEAF0 + i] = {req[i], pr, IDX_W'(i)};
    end

    for (genvar n = 0; n < LEAF0; n++) begin : g_node
        cand_t lo;
        cand_t hi;
        assign lo = node[2*n + 1];
        assign hi = node[2*n + 2];
        if (BY_PRIO) begin : g_prio
            assign node[n] = (hi.vld && (!lo.vld || hi.prio >= lo.prio)) ? hi : lo;
        end else begin : g_low
            assign node[n] = lo.vld ? lo : hi;
        end
    end

    assign win = node[0];
endmodule

// File: rtl/irq_prio_arbiter.sv
module irq_prio_arbiter
    import irqa_pkg::*;
#(
    parameter int N  = SRC_N,
    parameter int PW = PRIO_W,
    parameter int MW = MASK_W,
    parameter int VW = VEC_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [N-1:0]   src_lvl,
    input  logic           en_wr,
    input  logic [N-1:0]   en_val,
    input  logic           fast_wr,
    input  logic [N-1:0]   fast_val,
    input  logic           prio_wr,
    input  logic [N*PW-1:0] prio_val,
    input  logic           mask_wr,
    input  logic [MW-1:0]  mask_val,
    input  logic           nack,
    input  logic           fack,
    output logic           nreq,
    output logic           freq,
    output logic [VW-1:0]  nvec,
    output logic [VW-1:0]  fvec
);
    localparam int HALF = VW / 2;

    logic [N-1:0]    en_q, fast_q, pend_q;
    logic [N*PW-1:0] prio_q;
    logic [MW-1:0]   mask_q;
    logic [N-1:0]    ncand, fcand, nclr, fclr;
    cand_t           nwin, fwin;
    logic            nreq_d, freq_d, nreq_q, freq_q;

    irqa_cfg_regs #(.N(N), .PW(PW), .MW(MW)) u_cfg (
        .clk(clk), .rst_n(rst_n),
        .en_wr(en_wr), .en_val(en_val),
        .fast_wr(fast_wr), .fast_val(fast_val),
        .prio_wr(prio_wr), .prio_val(prio_val),
        .mask_wr(mask_wr), .mask_val(mask_val),
        .en_q(en_q), .fast_q(fast_q), .prio_q(prio_q), .mask_q(mask_q)
    );

    irqa_pend_bank #(.N(N)) u_pend (
        .clk(clk), .rst_n(rst_n), .lvl(src_lvl),
        .clr(nclr | fclr), .pend_q(pend_q)
    );

    assign ncand = pend_q & en_q & ~fast_q;
    assign fcand = pend_q & en_q & fast_q;

    irqa_pick_tree #(.N(N), .PW(PW), .BY_PRIO(1'b1)) u_ntree (
        .req(ncand), .prio(prio_q), .win(nwin)
    );

    irqa_pick_tree #(.N(N), .PW(PW), .BY_PRIO(1'b0)) u_ftree (
        .req(fcand), .prio(prio_q), .win(fwin)
    );

    assign nclr = (nack && nwin.vld) ? (N'(1) << nwin.idx) : '0;
    assign fclr = (fack && fwin.vld) ? (N'(1) << fwin.idx) : '0;

    always_comb begin
        freq_d = fwin.vld;
        nreq_d = nwin.vld && ((mask_q == '1) || (MW'(nwin.prio) > mask_q));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nreq_q <= 1'b0;
            freq_q <= 1'b0;
        end else begin
            nreq_q <= nreq_d;
            freq_q <= freq_d;
        end
    end

    assign nreq = nreq_q;
    assign freq = freq_q;
    assign nvec = nwin.vld ? {HALF'(nwin.idx), HALF'(nwin.prio)} : '1;
    assign fvec = fwin.vld ? VW'(fwin.idx) : '1;

    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> (!nreq_q && !freq_q && pend_q == '0));

    p_freq_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fcand != '0) |=> freq_q);

    p_freq_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fcand == '0) |=> !freq_q);

    p_nreq_open_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '1 && ncand != '0) |=> nreq_q);

    p_nreq_block_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q != '1 && MW'(nwin.prio) <= mask_q) |=> !nreq_q);

    p_nreq_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ncand == '0) |=> !nreq_q);

    p_nvec_none_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ncand == '0) |-> (nvec == '1));

    p_nvec_member_r6: assert property (@(posedge clk) disable iff (!rst_n)
        nwin.vld |-> ncand[nwin.idx]);

    p_nack_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (nack && nwin.vld) |=> !pend_q[$past(nwin.idx)]);

    p_fack_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fack && fwin.vld) |=> !pend_q[$past(fwin.idx)]);

    p_fvec_lowest_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fwin.vld |-> ((fcand & ((N'(1) << fwin.idx) - N'(1))) == '0));
endmodule

// File: tb/irq_prio_arbiter_bench.sv
module irq_prio_arbiter_bench;
    localparam int CLK_P = 10;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [63:0]   src_lvl, en_val, fast_val;
    logic [255:0]  prio_val;
    logic [4:0]    mask_val;
    logic          en_wr, fast_wr, prio_wr, mask_wr, nack, fack;
    logic          nreq, freq;
    logic [31:0]   nvec, fvec;

    int checks = 0;
    int errors = 0;

    logic [63:0]  m_pend, m_lvl_q, m_en, m_fast;
    logic [255:0] m_prio;
    logic [4:0]   m_mask;

    always #(CLK_P/2) clk = ~clk;

    irq_prio_arbiter u_irq_prio_arbiter (
        .clk(clk), .rst_n(rst_n), .src_lvl(src_lvl),
        .en_wr(en_wr), .en_val(en_val), .fast_wr(fast_wr), .fast_val(fast_val),
        .prio_wr(prio_wr), .prio_val(prio_val), .mask_wr(mask_wr), .mask_val(mask_val),
        .nack(nack), .fack(fack), .nreq(nreq), .freq(freq), .nvec(nvec), .fvec(fvec)
    );

    task automatic chk(input string tag, input string what, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s got %h exp %h", tag, what, got, exp);
        end
    endtask

    function automatic logic [31:0] m_nvec();
        int bi = -1;
        int bp = -1;
        for (int i = 0; i < 64; i++) begin
            if (m_pend[i] && m_en[i] && !m_fast[i]) begin
                int p = int'(m_prio[i*4 +: 4]);
                if (p >= bp) begin
                    bp = p;
                    bi = i;
                end
            end
        end
        if (bi < 0) return '1;
        return {16'(bi), 16'(bp)};
    endfunction

    function automatic logic [31:0] m_fvec();
        for (int i = 0; i < 64; i++)
            if (m_pend[i] && m_en[i] && m_fast[i]) return 32'(i);
        return '1;
    endfunction

    function automatic logic m_nreq();
        logic [31:0] v = m_nvec();
        if (v == '1) return 1'b0;
        return (m_mask == 5'h1F) || ({1'b0, v[3:0]} > m_mask);
    endfunction

    function automatic logic m_freq();
        return (m_pend & m_en & m_fast) != '0;
    endfunction

    // one clock: inputs already applied just after a falling edge
    task automatic cyc(input string ctx);
        logic [31:0] pn, pf;
        logic        en_n, en_f;
        logic [63:0] clr;
        pn = m_nvec();
        pf = m_fvec();
        en_n = m_nreq();
        en_f = m_freq();
        clr = '0;
        if (nack && pn != '1) clr[pn[21:16]] = 1'b1;
        if (fack && pf != '1) clr[pf[5:0]] = 1'b1;
        @(posedge clk);
        m_pend  = (m_pend | (src_lvl & ~m_lvl_q)) & ~(~src_lvl & m_lvl_q) & ~clr;
        m_lvl_q = src_lvl;
        if (en_wr)   m_en   = en_val;
        if (fast_wr) m_fast = fast_val;
        if (prio_wr) m_prio = prio_val;
        if (mask_wr) m_mask = mask_val;
        @(negedge clk);
        #1;
        en_wr = 0; fast_wr = 0; prio_wr = 0; mask_wr = 0; nack = 0; fack = 0;
        chk("R6", {"nvec ", ctx}, nvec, m_nvec());
        chk("R8", {"fvec ", ctx}, fvec, m_fvec());
        chk("R5", {"nreq ", ctx}, {31'b0, nreq}, {31'b0, en_n});
        chk("R3", {"freq ", ctx}, {31'b0, freq}, {31'b0, en_f});
    endtask

    initial begin
        #(CLK_P * 150000);
        errors++;
        $display("FAIL R1 watchdog got timeout exp completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 0; src_lvl = '0; en_val = '0; fast_val = '0; prio_val = '0; mask_val = '0;
        en_wr = 0; fast_wr = 0; prio_wr = 0; mask_wr = 0; nack = 0; fack = 0;
        m_pend = '0; m_lvl_q = '0; m_en = '0; m_fast = '0; m_prio = '0; m_mask = 5'h1F;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        #1;
        chk("R1", "nvec after reset", nvec, 32'hFFFF_FFFF);
        chk("R1", "fvec after reset", fvec, 32'hFFFF_FFFF);
        chk("R1", "nreq after reset", {31'b0, nreq}, 32'd0);
        chk("R1", "freq after reset", {31'b0, freq}, 32'd0);

        // R4: threshold resets to all ones, so a priority-0 source requests
        en_val = 64'h20; en_wr = 1; src_lvl[5] = 1;
        cyc("R4 rise");
        chk("R2", "source 5 pending after rise", nvec, 32'h0005_0000);
        cyc("R4 hold");
        chk("R4", "nreq with reset threshold", {31'b0, nreq}, 32'd1);

        // R10 layout, R6 tie toward the higher index
        prio_val = '0; prio_val[9*4 +: 4] = 4'd7; prio_val[3*4 +: 4] = 4'd7; prio_wr = 1;
        en_val = 64'h228; en_wr = 1; src_lvl[3] = 1; src_lvl[9] = 1;
        cyc("R10 load");
        chk("R10", "nibble layout and tie", nvec, 32'h0009_0007);

        // R5 strict threshold
        mask_val = 5'd7; mask_wr = 1; cyc("R5 m7"); cyc("R5 m7b");
        chk("R5", "prio equal to threshold", {31'b0, nreq}, 32'd0);
        mask_val = 5'd6; mask_wr = 1; cyc("R5 m6"); cyc("R5 m6b");
        chk("R5", "prio above threshold", {31'b0, nreq}, 32'd1);
        mask_val = 5'h10; mask_wr = 1; cyc("R5 m16"); cyc("R5 m16b");
        chk("R5", "threshold 16 blocks", {31'b0, nreq}, 32'd0);
        mask_val = 5'h1F; mask_wr = 1; cyc("R5 restore");

        // R7 acknowledge sequence
        nack = 1; cyc("R7 a1");
        chk("R7", "after first ack", nvec, 32'h0003_0007);
        nack = 1; cyc("R7 a2");
        chk("R7", "after second ack", nvec, 32'h0005_0000);
        nack = 1; cyc("R7 a3");
        chk("R7", "after third ack", nvec, 32'hFFFF_FFFF);
        nack = 1; cyc("R7 empty");
        chk("R7", "ack with no candidate", nvec, 32'hFFFF_FFFF);

        // R9 stays retired while level is high
        repeat (3) cyc("R9 hold");
        chk("R9", "no re-pend while level high", nvec, 32'hFFFF_FFFF);
        src_lvl[9] = 0; cyc("R9 low");
        src_lvl[9] = 1; cyc("R9 rise");
        chk("R9", "re-pend on new rise", nvec, 32'h0009_0007);
        src_lvl[9] = 0; cyc("R2 fall");
        chk("R2", "fall clears pending", nvec, 32'hFFFF_FFFF);

        // R8 / R11 fast class
        fast_val = (64'd1 << 20) | (64'd1 << 40); fast_wr = 1;
        en_val = 64'h228 | (64'd1 << 20) | (64'd1 << 40); en_wr = 1;
        prio_val[40*4 +: 4] = 4'hF; prio_wr = 1;
        src_lvl[20] = 1; src_lvl[40] = 1; src_lvl[50] = 1;
        cyc("R8 setup");
        chk("R8", "lowest fast index", fvec, 32'd20);
        chk("R11", "fast and disabled excluded from normal", nvec, 32'hFFFF_FFFF);
        cyc("R8 req");
        chk("R11", "no normal request from fast sources", {31'b0, nreq}, 32'd0);
        fack = 1; cyc("R8 ack1");
        chk("R8", "next fast index", fvec, 32'd40);
        fack = 1; cyc("R8 ack2");
        chk("R8", "fast empty", fvec, 32'hFFFF_FFFF);
        cyc("R8 drop");
        chk("R3", "fast request drops", {31'b0, freq}, 32'd0);

        // random traffic
        for (int c = 0; c < 4000; c++) begin
            for (int k = 0; k < 3; k++)
                if ($urandom % 3 == 0) src_lvl[$urandom % 64] ^= 1'b1;
            if ($urandom % 16 == 0) begin en_val = {$urandom, $urandom}; en_wr = 1; end
            if ($urandom % 24 == 0) begin
                fast_val = {$urandom, $urandom} & {$urandom, $urandom}; fast_wr = 1;
            end
            if ($urandom % 20 == 0) begin
                for (int w = 0; w < 8; w++)
                    prio_val[w*32 +: 32] = ($urandom % 2 == 0) ? $urandom : ($urandom & 32'h3131_1313);
                prio_wr = 1;
            end
            if ($urandom % 12 == 0) begin
                case ($urandom % 3)
                    0: mask_val = 5'h1F;
                    1: mask_val = 5'($urandom % 16);
                    default: mask_val = 5'(16 + $urandom % 15);
                endcase
                mask_wr = 1;
            end
            nack = ($urandom % 5 == 0);
            fack = ($urandom % 7 == 0);
            cyc("random");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule